// File: doc/BRIEF.md
# Routable Three-Source Interrupt Controller

This block collects three interrupt sources for a signal-processing core: a request raised by a host processor, a conversion-done strobe from an ADC and an event strobe from a timer. Each source sets its own pending flag. A three-bit routing code decides which of three prioritized interrupt lines each source drives. Each line has its own mask bit, and one global enable gates all three lines. The core clears a pending flag by writing a one to a clear bit. Clear bits are not stored.

The core can also raise a request back toward the host. The host acknowledges it with a register write. The request then drops by itself after a fixed number of host instruction completions, and these completions are signalled by a strobe input. Both sides reach the block through plain single-cycle register ports. No data stream passes through the block, so there is no valid/ready handshake. Every pin is a plain control or status signal. A write takes effect at the clock edge where its strobe is high. Read data is combinational from the address.

Top module: `irq_router_top`

## Requirements
- R1: After reset, all three pending flags are 0, the routing code is 000, all mask bits are 0, the global enable is 0, `int_line` is 000 and `host_irq` is 0.
- R2: A host write with `host_wdata[0]`=1 sets the host pending flag. The flag reads on `host_rdata[0]` and on core status bit 0 (`dsp_addr`=1).
- R3: An `adc_done` pulse sets the ADC pending flag, which reads on status bit 1. A `tmr_evt` pulse sets the timer pending flag, which reads on status bit 2.
- R4: A core write to address 1 with bit 4, 5 or 6 set clears the host, ADC or timer pending flag respectively. A zero in those bits leaves the flag unchanged. Status bits 6..3 always read as 0.
- R5: If a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: Routing code (control bits 2..0) maps (host, ADC, timer) to lines as follows: 000 gives (2,1,0), 001 gives (1,2,0), 010 gives (2,0,1), 011 gives (1,0,2), 100 gives (0,2,1) and 101 gives (0,1,2).
- R7: Routing codes 110 and 111 drive no line. In that case `int_line` stays 000 whatever the pending state.
- R8: `int_line[k]` is 1 exactly when a pending source is routed to line k, mask bit k (control bit 3+k) is 1 and the global enable (control bit 6) is 1.
- R9: A core write to address 0 loads the routing code, the masks and the enable. A read of address 0 returns them in bits 6..0, with bit 7 reading as 0.
- R10: A core write to address 1 with bit 7 set raises `host_irq`. This write also cancels any acknowledge countdown in progress. The request reads on `host_rdata[1]` and on status bit 7.
- R11: A host write with `host_wdata[1]`=1 while the request is raised and not yet acknowledged starts a countdown. `host_irq` falls at the edge of the third `host_step` strobe after the acknowledge. A strobe in the acknowledge cycle itself does not count. An acknowledge while the request is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_wr | input | 1 | Core register write strobe |
| dsp_addr | input | 1 | Core register select: 0 = control, 1 = status/clear |
| dsp_wdata | input | 8 | Core write data |
| dsp_rdata | output | 8 | Core read data for `dsp_addr` |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 2 | Bit 0 raises host request, bit 1 acknowledges core request |
| host_rdata | output | 2 | Bit 0 host pending flag, bit 1 core-to-host request |
| host_step | input | 1 | Host instruction-complete strobe |
| adc_done | input | 1 | ADC conversion-done strobe |
| tmr_evt | input | 1 | Timer event strobe |
| int_line | output | 3 | Interrupt lines INT0..INT2 toward the core |
| host_irq | output | 1 | Request toward the host |

## Verification
The bench drives events and clear writes into the same flag in the same cycle. A design where the clear takes priority would lose that event, and the flag would read 0. It steps through all eight routing codes with single sources pending. A mis-wired table would light the wrong line, and a design that does not block the reserved codes would assert some line under 110 or 111. It counts the `host_step` strobes after an acknowledge, with a strobe placed in the acknowledge cycle. An off-by-one countdown would drop `host_irq` one strobe early or late. An acknowledge given while the request is low must leave it low, and a design that accepts it would arm a stale countdown.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC = 3;
  localparam int NLINE = 3;
  localparam int DW = 8;
  localparam int LW = 2;

  typedef enum logic [1:0] {SRC_HOST = 2'd0, SRC_ADC = 2'd1, SRC_TMR = 2'd2} src_e;

  localparam logic [LW-1:0] LINE_NONE = 2'd3;

  // Packed map {tmr, adc, host}, two bits per source; LINE_NONE marks reserved.
  function automatic logic [NSRC*LW-1:0] route_map(input logic [2:0] code);
    logic [NSRC*LW-1:0] m;
    case (code)
      3'd0: m = {2'd0, 2'd1, 2'd2};
      3'd1: m = {2'd0, 2'd2, 2'd1};
      3'd2: m = {2'd1, 2'd0, 2'd2};
      3'd3: m = {2'd2, 2'd0, 2'd1};
      3'd4: m = {2'd1, 2'd2, 2'd0};
      3'd5: m = {2'd2, 2'd1, 2'd0};
      default: m = {LINE_NONE, LINE_NONE, LINE_NONE};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/irq_pend_flag.sv
module irq_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
  import irq_router_pkg::*;
(
  input  logic [2:0]       code,
  input  logic [NSRC-1:0]  pend,
  output logic [NLINE-1:0] line_raw
);
  logic [NSRC*LW-1:0] map;
  logic [NLINE-1:0][NSRC-1:0] hit;

  assign map = route_map(code);

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign hit[l][s] = pend[s] && (map[s*LW +: LW] == LW'(l));
    end
    assign line_raw[l] = |hit[l];
  end
endmodule

// File: rtl/irq_host_req.sv
module irq_host_req #(
  parameter int ACK_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic step,
  output logic req
);
  localparam int CW = $clog2(ACK_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DELAY - 1);

  logic armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      armed <= 1'b0;
      cnt <= '0;
    end else if (set) begin
      req <= 1'b1;
      armed <= 1'b0;
      cnt <= '0;
    end else if (armed && step) begin
      if (cnt == LAST) begin
        req <= 1'b0;
        armed <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (ack && req && !armed) begin
      armed <= 1'b1;
      cnt <= '0;
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int ACK_DELAY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dsp_wr,
  input  logic          dsp_addr,
  input  logic [DW-1:0] dsp_wdata,
  output logic [DW-1:0] dsp_rdata,
  input  logic          host_wr,
  input  logic [1:0]    host_wdata,
  output logic [1:0]    host_rdata,
  input  logic          host_step,
  input  logic          adc_done,
  input  logic          tmr_evt,
  output logic [NLINE-1:0] int_line,
  output logic          host_irq
);
  localparam int MASK_LSB = 3;
  localparam int GEN_BIT = 6;
  localparam int CLR_LSB = 4;
  localparam int REQ_BIT = 7;

  logic [2:0]       route;
  logic [NLINE-1:0] mask;
  logic             gen_en;
  logic [NSRC-1:0]  pend, set_v, clr_v;
  logic [NLINE-1:0] line_raw;
  logic             wr_ctl, wr_stat;

  assign wr_ctl  = dsp_wr && !dsp_addr;
  assign wr_stat = dsp_wr && dsp_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route <= '0;
      mask <= '0;
      gen_en <= 1'b0;
    end else if (wr_ctl) begin
      route <= dsp_wdata[2:0];
      mask <= dsp_wdata[MASK_LSB +: NLINE];
      gen_en <= dsp_wdata[GEN_BIT];
    end
  end

  assign set_v[SRC_HOST] = host_wr && host_wdata[0];
  assign set_v[SRC_ADC]  = adc_done;
  assign set_v[SRC_TMR]  = tmr_evt;

  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    assign clr_v[s] = wr_stat && dsp_wdata[CLR_LSB + s];
    irq_pend_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(set_v[s]), .clr(clr_v[s]), .q(pend[s])
    );
  end

  irq_route_xbar u_xbar (.code(route), .pend(pend), .line_raw(line_raw));

  assign int_line = line_raw & mask & {NLINE{gen_en}};

  irq_host_req #(.ACK_DELAY(ACK_DELAY)) u_req (
    .clk(clk), .rst_n(rst_n),
    .set(wr_stat && dsp_wdata[REQ_BIT]),
    .ack(host_wr && host_wdata[1]),
    .step(host_step),
    .req(host_irq)
  );

  always_comb begin
    dsp_rdata = '0;
    if (!dsp_addr) begin
      dsp_rdata[2:0] = route;
      dsp_rdata[MASK_LSB +: NLINE] = mask;
      dsp_rdata[GEN_BIT] = gen_en;
    end else begin
      dsp_rdata[NSRC-1:0] = pend;
      dsp_rdata[REQ_BIT] = host_irq;
    end
  end

  assign host_rdata = {host_irq, pend[SRC_HOST]};
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dsp_wr,
  input logic       dsp_addr,
  input logic [7:0] dsp_wdata,
  input logic       host_wr,
  input logic [1:0] host_wdata,
  input logic       host_step,
  input logic       adc_done,
  input logic       tmr_evt,
  input logic [2:0] int_line,
  input logic       host_irq,
  input logic [2:0] pend,
  input logic [2:0] route,
  input logic       gen_en
);
  AST_HOST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_wdata[0] |=> pend[0]); // R2
  AST_ADC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> pend[1]); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt && dsp_wr && dsp_addr && dsp_wdata[6] |=> pend[2]); // R5
  AST_CLR_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_wr && dsp_addr && dsp_wdata[5] && !adc_done |=> !pend[1]); // R4
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    route[2:1] == 2'b11 |-> int_line == 3'b000); // R7
  AST_GEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> int_line == 3'b000); // R8
  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_wr && dsp_addr && dsp_wdata[7] |=> host_irq); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && !host_step |=> host_irq); // R11
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_irq && !(dsp_wr && dsp_addr && dsp_wdata[7]) |=> !host_irq); // R11
endmodule

bind irq_router_top irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dsp_wr(dsp_wr), .dsp_addr(dsp_addr),
  .dsp_wdata(dsp_wdata), .host_wr(host_wr), .host_wdata(host_wdata),
  .host_step(host_step), .adc_done(adc_done), .tmr_evt(tmr_evt),
  .int_line(int_line), .host_irq(host_irq), .pend(pend), .route(route),
  .gen_en(gen_en)
);

// File: tb/tb_irq_router_top.sv
module tb_irq_router_top;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dsp_wr = 0, dsp_addr = 0;
  logic [7:0] dsp_wdata = 0, dsp_rdata;
  logic host_wr = 0;
  logic [1:0] host_wdata = 0, host_rdata;
  logic host_step = 0, adc_done = 0, tmr_evt = 0;
  logic [2:0] int_line;
  logic host_irq;

  int n_tests = 0, n_fail = 0, cyc = 0;

  logic [2:0] m_pend, m_route, m_mask;
  logic m_gen, m_req, m_arm;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router_top #(.ACK_DELAY(DELAY)) dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Line for source s (0 host, 1 adc, 2 tmr) under a code; 3 = none.
  function automatic int line_for(input logic [2:0] code, input int s);
    int host_l[6] = '{2, 1, 2, 1, 0, 0};
    int adc_l[6]  = '{1, 2, 0, 0, 2, 1};
    int tmr_l[6]  = '{0, 0, 1, 2, 1, 2};
    if (code > 5) return 3;
    if (s == 0) return host_l[code];
    if (s == 1) return adc_l[code];
    return tmr_l[code];
  endfunction

  function automatic logic [2:0] exp_lines();
    logic [2:0] r = 0;
    for (int s = 0; s < 3; s++)
      if (m_pend[s] && line_for(m_route, s) < 3) r[line_for(m_route, s)] = 1'b1;
    return r & m_mask & {3{m_gen}};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(m_route > 5 ? "R7" : "R6/R8", int_line, exp_lines());
    chk("R10", host_irq, m_req);
    chk("R2", host_rdata, {m_req, m_pend[0]});
    if (dsp_addr) chk("R4", dsp_rdata, {m_req, 4'b0, m_pend});
    else chk("R9", dsp_rdata, {1'b0, m_gen, m_mask, m_route});
  endtask

  task automatic model_update();
    logic [2:0] set_v, clr_v;
    logic rset, ack;
    set_v = {tmr_evt, adc_done, host_wr & host_wdata[0]};
    clr_v = (dsp_wr && dsp_addr) ? dsp_wdata[6:4] : 3'b0;
    m_pend = set_v | (m_pend & ~clr_v);
    if (dsp_wr && !dsp_addr) begin
      m_route = dsp_wdata[2:0];
      m_mask = dsp_wdata[5:3];
      m_gen = dsp_wdata[6];
    end
    rset = dsp_wr && dsp_addr && dsp_wdata[7];
    ack = host_wr && host_wdata[1];
    if (rset) begin m_req = 1; m_arm = 0; m_cnt = 0; end
    else if (m_arm && host_step) begin
      if (m_cnt == DELAY - 1) begin m_req = 0; m_arm = 0; m_cnt = 0; end
      else m_cnt++;
    end else if (ack && m_req && !m_arm) begin m_arm = 1; m_cnt = 0; end
  endtask

  // Inputs already driven at negedge: check, clock, return to negedge.
  task automatic cycle();
    #1 check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    dsp_wr = 0; host_wr = 0; host_step = 0; adc_done = 0; tmr_evt = 0;
  endtask

  task automatic dsp_write(input logic a, input logic [7:0] d);
    idle(); dsp_wr = 1; dsp_addr = a; dsp_wdata = d; cycle(); idle();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_pend = 0; m_route = 0; m_mask = 0; m_gen = 0; m_req = 0; m_arm = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", int_line, 0); chk("R1", host_irq, 0); chk("R1", host_rdata, 0);
    dsp_addr = 0; #1 chk("R1", dsp_rdata, 0);
    dsp_addr = 1; #1 chk("R1", dsp_rdata, 0);

    // R6/R7: every code, one source at a time, all lines unmasked.
    for (int code = 0; code < 8; code++) begin
      for (int s = 0; s < 3; s++) begin
        dsp_write(0, {1'b0, 1'b1, 3'b111, 3'(code)});
        dsp_write(1, 8'h70);
        idle();
        if (s == 0) begin host_wr = 1; host_wdata = 2'b01; end
        if (s == 1) adc_done = 1;
        if (s == 2) tmr_evt = 1;
        cycle(); idle(); #1;
        chk(code > 5 ? "R7" : "R6", int_line,
            code > 5 ? 0 : (1 << line_for(3'(code), s)));
        cycle();
      end
    end

    // R5: set and clear of the ADC flag in the same cycle.
    dsp_write(1, 8'h70);
    idle(); adc_done = 1; dsp_wr = 1; dsp_addr = 1; dsp_wdata = 8'h20;
    cycle(); idle(); dsp_addr = 1; #1;
    chk("R5", dsp_rdata[1], 1);
    cycle();

    // R11: ack with strobe in same cycle, then count strobes.
    idle(); host_wr = 1; host_wdata = 2'b10; cycle();
    chk("R11", host_irq, 0);
    dsp_write(1, 8'h80);
    idle(); host_wr = 1; host_wdata = 2'b10; host_step = 1; cycle();
    for (int k = 1; k <= DELAY; k++) begin
      idle(); host_step = 1; cycle(); idle(); #1;
      chk("R11", host_irq, k < DELAY);
      cycle();
    end

    // Random phase, model-checked every cycle.
    for (int i = 0; i < 4000; i++) begin
      idle();
      dsp_wr = ($urandom_range(0, 99) < 30);
      dsp_addr = $urandom_range(0, 1);
      dsp_wdata = 8'($urandom);
      if (dsp_addr && $urandom_range(0, 9) != 0) dsp_wdata[7] = 1'b0;
      host_wr = ($urandom_range(0, 99) < 20);
      host_wdata = 2'($urandom);
      host_step = ($urandom_range(0, 99) < 40);
      adc_done = ($urandom_range(0, 99) < 15);
      tmr_evt = ($urandom_range(0, 99) < 15);
      cycle();
    end

    idle(); cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule